// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Aggregator

This block collects interrupt requests from a board and presents them to a processor as two interrupt lines. Sixteen level-sensitive request lines form two local groups of eight. Eight further lines form a shared mappable group. That group is gated by two independent mask registers. Each masked result is reduced to a single bit, and that bit is folded into a fixed position of one of the local groups. Two timer request lines are edge-captured into sticky latches, which software clears with a write-one register.

Software reads the status registers through a small word-addressed register bus to find out which sources are pending. It enables sources through read-modify-write of the mask registers. Each processor line is the registered OR of one local group's status ANDed with that group's mask. All external lines pass through a two-stage synchronizer before any register sees them.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, all four mask registers read 0, both timer latches read 0 and `cpu_irq_o` is 0, even while request lines are high.
- R2: The register index is `reg_addr[4:2]`: 0 local group 0 status, 1 group 0 mask, 2 local group 1 status, 3 group 1 mask, 4 mappable status, 5 mappable mask A, 6 mappable mask B, 7 timer latches. A write to a mask register takes `reg_wdata[7:0]` at the clock edge. A read returns the last value written in bits 7:0 and zeros above.
- R3: Group 0 status bit i follows `local_irq_i[i]`, group 1 status bit i follows `local_irq_i[8+i]`, and mappable status follows `map_irq_i` without masking. Each is visible on a read two clock edges after the line changes.
- R4: Writes to the three status registers (index 0, 2, 4) change nothing that a read returns.
- R5: Group 0 status bit 7 is also set whenever (mappable status AND mask A) is nonzero.
- R6: Group 1 status bit 3 is also set whenever (mappable status AND mask B) is nonzero.
- R7: `cpu_irq_o[g]` is registered. It equals the OR of group g's status ANDed with group g's mask, and it follows that value one clock edge after the value changes.
- R8: A rising edge on `timer_irq_i[t]` sets latch t, read at index 7 bit t, three edges after the rise. The latch stays set after the line falls. A line that is held high does not set the latch again.
- R9: A write to index 7 clears latch t when `reg_wdata[t]` is 1 and leaves it unchanged when it is 0. Writing 0x3 clears both latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Byte address of the register; bits 4:2 select it |
| reg_wen | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational from registered state |
| local_irq_i | input | 16 | Local request lines; bits 7:0 group 0, bits 15:8 group 1 |
| map_irq_i | input | 8 | Mappable request lines |
| timer_irq_i | input | 2 | Timer request lines, edge-captured |
| cpu_irq_o | output | 2 | Processor interrupt lines, one per local group |

## Verification
Each result has a fixed time at which it becomes due. A register write shows on a read at the first falling edge after it. A status change is due two rising edges after the input moves. A processor line is due three edges after an input moves, or one edge after a mask write. A timer latch sets three edges after a rise. The driver pushes each expectation with the cycle it is due. Around the processor line it also pushes the value the line holds one cycle earlier, so a design that is a cycle early or late fails. The monitor compares each expectation shortly after the falling edge of its due cycle, when inputs and outputs are stable.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    // Register index taken from the word address bits
    typedef enum logic [2:0] {
        RI_L0_STAT   = 3'd0,
        RI_L0_MASK   = 3'd1,
        RI_L1_STAT   = 3'd2,
        RI_L1_MASK   = 3'd3,
        RI_MAP_STAT  = 3'd4,
        RI_MAP_MASKA = 3'd5,
        RI_MAP_MASKB = 3'd6,
        RI_TMR_LATCH = 3'd7
    } reg_idx_e;

    localparam int REG_IDX_W = 3;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d      = lat_q;
        lat_d.prev = lvl;
        // a fresh edge in the same cycle as a clear keeps the latch set
        lat_d.pend = (lat_q.pend & ~clr) | (lvl & ~lat_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign pend = lat_q.pend;
endmodule

// File: rtl/irq_cascade_eval.sv
module irq_cascade_eval #(
    parameter int GRP_W    = 8,
    parameter int CAS0_BIT = 7,
    parameter int CAS1_BIT = 3
) (
    input  logic [GRP_W-1:0] loc0_lvl,
    input  logic [GRP_W-1:0] loc1_lvl,
    input  logic [GRP_W-1:0] map_lvl,
    input  logic [GRP_W-1:0] mask_a,
    input  logic [GRP_W-1:0] mask_b,
    output logic [GRP_W-1:0] stat0,
    output logic [GRP_W-1:0] stat1
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [GRP_W-1:0] fold0, fold1;

    always_comb begin
        fold0           = '0;
        fold1           = '0;
        fold0[CAS0_BIT] = |(map_lvl & mask_a);
        fold1[CAS1_BIT] = |(map_lvl & mask_b);
        stat0           = loc0_lvl | fold0;
        stat1           = loc1_lvl | fold1;
    end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irq_cascade_pkg::*;
#(
    parameter int GRP_W       = 8,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 5,
    parameter int N_TMR       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int CAS0_BIT    = 7,
    parameter int CAS1_BIT    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wen,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [2*GRP_W-1:0]   local_irq_i,
    input  logic [GRP_W-1:0]     map_irq_i,
    input  logic [N_TMR-1:0]     timer_irq_i,
    output logic [1:0]           cpu_irq_o
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int N_LOCAL = 2 * GRP_W;
    localparam int SYNC_W  = N_LOCAL + GRP_W + N_TMR;
    localparam int IDX_W   = ADDR_W - 2;

    typedef struct packed {
        logic [GRP_W-1:0] l0_mask;
        logic [GRP_W-1:0] l1_mask;
        logic [GRP_W-1:0] mask_a;
        logic [GRP_W-1:0] mask_b;
        logic [1:0]       cpu_irq;
    } state_t;

    state_t st_d, st_q;

    logic [SYNC_W-1:0] sync_lvl;
    logic [N_LOCAL-1:0] loc_lvl;
    logic [GRP_W-1:0]   map_lvl;
    logic [N_TMR-1:0]   tmr_lvl;
    logic [GRP_W-1:0]   l0_stat, l1_stat;
    logic [N_TMR-1:0]   tmr_clr, tmr_pend;
    logic [IDX_W-1:0]   idx;
    logic               unused_bits;

    assign idx         = reg_addr[ADDR_W-1:2];
    assign unused_bits = ^{reg_wdata[DATA_W-1:GRP_W], reg_addr[1:0]};

    irq_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({timer_irq_i, map_irq_i, local_irq_i}),
        .dout (sync_lvl)
    );

    assign loc_lvl = sync_lvl[N_LOCAL-1:0];
    assign map_lvl = sync_lvl[N_LOCAL +: GRP_W];
    assign tmr_lvl = sync_lvl[N_LOCAL+GRP_W +: N_TMR];

    irq_cascade_eval #(.GRP_W(GRP_W), .CAS0_BIT(CAS0_BIT), .CAS1_BIT(CAS1_BIT)) u_eval (
        .loc0_lvl(loc_lvl[GRP_W-1:0]),
        .loc1_lvl(loc_lvl[N_LOCAL-1:GRP_W]),
        .map_lvl (map_lvl),
        .mask_a  (st_q.mask_a),
        .mask_b  (st_q.mask_b),
        .stat0   (l0_stat),
        .stat1   (l1_stat)
    );

    assign tmr_clr = (reg_wen && idx == IDX_W'(RI_TMR_LATCH)) ? reg_wdata[N_TMR-1:0] : '0;

    irq_edge_latch #(.N(N_TMR)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (tmr_lvl),
        .clr  (tmr_clr),
        .pend (tmr_pend)
    );

    always_comb begin
        st_d = st_q;
        if (reg_wen) begin
            case (idx)
                IDX_W'(RI_L0_MASK):   st_d.l0_mask = reg_wdata[GRP_W-1:0];
                IDX_W'(RI_L1_MASK):   st_d.l1_mask = reg_wdata[GRP_W-1:0];
                IDX_W'(RI_MAP_MASKA): st_d.mask_a  = reg_wdata[GRP_W-1:0];
                IDX_W'(RI_MAP_MASKB): st_d.mask_b  = reg_wdata[GRP_W-1:0];
                default: ;
            endcase
        end
        st_d.cpu_irq = {|(l1_stat & st_q.l1_mask), |(l0_stat & st_q.l0_mask)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (idx)
            IDX_W'(RI_L0_STAT):   reg_rdata = DATA_W'(l0_stat);
            IDX_W'(RI_L0_MASK):   reg_rdata = DATA_W'(st_q.l0_mask);
            IDX_W'(RI_L1_STAT):   reg_rdata = DATA_W'(l1_stat);
            IDX_W'(RI_L1_MASK):   reg_rdata = DATA_W'(st_q.l1_mask);
            IDX_W'(RI_MAP_STAT):  reg_rdata = DATA_W'(map_lvl);
            IDX_W'(RI_MAP_MASKA): reg_rdata = DATA_W'(st_q.mask_a);
            IDX_W'(RI_MAP_MASKB): reg_rdata = DATA_W'(st_q.mask_b);
            default:              reg_rdata = DATA_W'(tmr_pend);
        endcase
    end

    assign cpu_irq_o = st_q.cpu_irq;
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
    import irq_cascade_pkg::*;
#(
    parameter int GRP_W    = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5,
    parameter int N_TMR    = 2,
    parameter int CAS0_BIT = 7,
    parameter int CAS1_BIT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wen,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [GRP_W-1:0]  l0_stat,
    input logic [GRP_W-1:0]  l1_stat,
    input logic [GRP_W-1:0]  map_stat,
    input logic [GRP_W-1:0]  l0_mask,
    input logic [GRP_W-1:0]  l1_mask,
    input logic [GRP_W-1:0]  mask_a,
    input logic [GRP_W-1:0]  mask_b,
    input logic [N_TMR-1:0]  tmr_pend,
    input logic [1:0]        cpu_irq
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [N_TMR-1:0] clr_vec;
    logic             unused_chk;

    assign idx        = reg_addr[ADDR_W-1:2];
    assign clr_vec    = (reg_wen && idx == IDX_W'(RI_TMR_LATCH)) ? reg_wdata[N_TMR-1:0] : '0;
    assign unused_chk = ^{reg_wdata[DATA_W-1:GRP_W], reg_addr[1:0]};

    // R2
    l0_mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && idx == IDX_W'(RI_L0_MASK)) |=> (l0_mask == $past(reg_wdata[GRP_W-1:0])));

    // R2
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wen |=> $stable({l0_mask, l1_mask, mask_a, mask_b}));

    // R5
    cascade_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(map_stat & mask_a)) |-> l0_stat[CAS0_BIT]);

    // R6
    cascade_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(map_stat & mask_b)) |-> l1_stat[CAS1_BIT]);

    // R7
    cpu_line0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cpu_irq[0] == $past(|(l0_stat & l0_mask))));

    // R7
    cpu_line1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cpu_irq[1] == $past(|(l1_stat & l1_mask))));

    // R8
    latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((tmr_pend & $past(tmr_pend & ~clr_vec)) == $past(tmr_pend & ~clr_vec)));
endmodule

bind irq_cascade_ctrl irq_cascade_chk #(
    .GRP_W(GRP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_TMR(N_TMR),
    .CAS0_BIT(CAS0_BIT), .CAS1_BIT(CAS1_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wen  (reg_wen),
    .reg_wdata(reg_wdata),
    .l0_stat  (l0_stat),
    .l1_stat  (l1_stat),
    .map_stat (map_lvl),
    .l0_mask  (st_q.l0_mask),
    .l1_mask  (st_q.l1_mask),
    .mask_a   (st_q.mask_a),
    .mask_b   (st_q.mask_b),
    .tmr_pend (tmr_pend),
    .cpu_irq  (cpu_irq_o)
);

// File: tb/irq_cascade_ctrl_test.sv
module irq_cascade_ctrl_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [4:0] A_L0S = 5'h00, A_L0M = 5'h04, A_L1S = 5'h08, A_L1M = 5'h0C;
    localparam logic [4:0] A_MPS = 5'h10, A_MMA = 5'h14, A_MMB = 5'h18, A_TMR = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] local_irq_i = '0;
    logic [7:0]  map_irq_i = '0;
    logic [1:0]  timer_irq_i = '0;
    logic [1:0]  cpu_irq_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int          due;
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];

    irq_cascade_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .local_irq_i(local_irq_i),
        .map_irq_i(map_irq_i), .timer_irq_i(timer_irq_i), .cpu_irq_o(cpu_irq_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares every expectation due by this cycle
    always @(negedge clk) begin
        #1;
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            item_t it;
            logic [31:0] act;
            it  = exp_q.pop_front();
            act = it.is_irq ? {30'b0, cpu_irq_o} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: act=%h exp=%h", it.tag, act, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc == 20000) begin
            errors++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        @(negedge clk);
        reg_wen   = 1'b0;
    endtask

    task automatic exp_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr  = a;
        it.due    = cyc;
        it.is_irq = 1'b0;
        it.exp    = e;
        it.tag    = tag;
        exp_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic exp_irq(input logic [1:0] e, input string tag);
        item_t it;
        it.due    = cyc;
        it.is_irq = 1'b1;
        it.exp    = {30'b0, e};
        it.tag    = tag;
        exp_q.push_back(it);
        @(negedge clk);
    endtask

    initial begin
        local_irq_i = 16'h2004;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        exp_rd(A_L0M, 32'h0, "R1 group0 mask");
        exp_rd(A_L1M, 32'h0, "R1 group1 mask");
        exp_rd(A_MMA, 32'h0, "R1 mask A");
        exp_rd(A_MMB, 32'h0, "R1 mask B");
        exp_rd(A_TMR, 32'h0, "R1 timer latches");
        exp_irq(2'b00, "R1 cpu lines");
        // R3 status follows levels
        exp_rd(A_L0S, 32'h04, "R3 group0 status");
        exp_rd(A_L1S, 32'h20, "R3 group1 status");
        // R2 mask write, upper bits dropped; R7 one-edge latency
        wr(A_L0M, 32'hFFFF_FF04);
        exp_irq(2'b00, "R7 line0 not yet");
        exp_irq(2'b01, "R7 line0 set");
        exp_rd(A_L0M, 32'h04, "R2 readback");
        wr(A_L1M, 32'h20);
        exp_irq(2'b01, "R7 line1 not yet");
        exp_irq(2'b11, "R7 both lines");
        // R4 status writes ignored
        wr(A_L0S, 32'h00);
        exp_rd(A_L0S, 32'h04, "R4 group0 status write");
        wr(A_MPS, 32'hFF);
        exp_rd(A_MPS, 32'h00, "R4 map status write");
        // R3/R7 deassert timing
        local_irq_i = 16'h0000;
        tick(2);
        exp_irq(2'b11, "R7 before fall");
        exp_irq(2'b00, "R7 after fall");
        // R5 cascade into group 0
        map_irq_i = 8'h08;
        tick(2);
        exp_rd(A_MPS, 32'h08, "R3 map status unmasked");
        exp_rd(A_L0S, 32'h00, "R5 mask A clear");
        wr(A_MMA, 32'h08);
        exp_rd(A_L0S, 32'h80, "R5 cascade bit");
        exp_rd(A_L1S, 32'h00, "R6 group1 untouched");
        wr(A_L0M, 32'h84);
        tick(1);
        exp_irq(2'b01, "R5 cascade to line0");
        // R6 cascade into group 1
        wr(A_MMB, 32'h08);
        exp_rd(A_L1S, 32'h08, "R6 cascade bit");
        wr(A_L1M, 32'h28);
        tick(1);
        exp_irq(2'b11, "R6 cascade to line1");
        wr(A_MMA, 32'h01);
        exp_rd(A_L0S, 32'h00, "R5 other mask bit");
        // R8 timer capture and hold
        timer_irq_i = 2'b01;
        tick(3);
        timer_irq_i = 2'b00;
        exp_rd(A_TMR, 32'h1, "R8 capture");
        tick(3);
        exp_rd(A_TMR, 32'h1, "R8 sticky");
        // R9 per-bit clear
        wr(A_TMR, 32'h2);
        exp_rd(A_TMR, 32'h1, "R9 zero bit keeps");
        wr(A_TMR, 32'h1);
        exp_rd(A_TMR, 32'h0, "R9 clear bit0");
        timer_irq_i = 2'b11;
        tick(3);
        exp_rd(A_TMR, 32'h3, "R8 both captured");
        wr(A_TMR, 32'h3);
        exp_rd(A_TMR, 32'h0, "R9 clear both");
        tick(3);
        exp_rd(A_TMR, 32'h0, "R8 held level no retrigger");
        timer_irq_i = 2'b00;
        tick(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule